// File: doc/BRIEF.md
# Interval Timer with Square-Wave Output

This block is one timer channel that produces a periodic interrupt pulse from one of two prescaled clock enables. Software starts it with a start strobe and halts it with a stop strobe. While it runs, a down-counter loaded from a reload value counts the selected enable ticks. Each time the counter passes through zero it raises a one-cycle interrupt and reloads, so the interrupt period is (reload + 1) selected ticks.

The wave pin has two sources. With the output enable low it drives a level that software sets. With the enable high, each interrupt event toggles it, which gives a square wave whose half-period is the interrupt period. A start-event bit can make the start itself raise an interrupt and toggle the wave. A narrow-mode bit turns the channel into an 8-bit timer that uses only the low byte of the reload value. Only mode value 000 (interval timing) is active. Any other mode value keeps the channel idle.

Top module: `itmr_channel`

## Requirements
- R1: Counting, interrupts and toggles happen only while `mode_i` equals 3'b000. With any other value a start is ignored, the counter stays idle and `irq_o` stays 0.
- R2: A start loads the counter from `reload_i`. `irq_o` is high for one clock cycle, in the cycle after the edge that samples the (reload+1)-th selected tick since the start, and again every (reload+1) ticks after that. A reload of 0 fires on every selected tick.
- R3: With `out_en_i` = 0, `wave_o` equals the `out_level_i` value sampled at the previous clock edge, and interrupt events do not affect it.
- R4: With `out_en_i` = 1, `wave_o` inverts in exactly the cycles in which `irq_o` is high. With ticks every cycle, this gives equal high and low phases of (reload+1) cycles each.
- R5: With `start_evt_i` = 1, a start raises `irq_o` in the following cycle and inverts `wave_o` once when `out_en_i` = 1. With `start_evt_i` = 0, a start raises no interrupt and no inversion.
- R6: `clk_sel_i` = 0 counts `tick0_i` and `clk_sel_i` = 1 counts `tick1_i`. Pulses on the unselected input have no effect.
- R7: With `narrow_i` = 1, the channel is 8 bits wide. Only `reload_i[7:0]` is used and the upper counter byte is held at zero, so a reload of 16'hFFFF gives a 256-tick period. With `narrow_i` = 0, the full 16 bits are used (65536 ticks at most).
- R8: `stop_i` halts counting. After it, no interrupt or toggle occurs and `wave_o` keeps its last level. When `stop_i` and `start_i` are high in the same cycle, stop wins.
- R9: While `out_en_i` = 1, changes of `out_level_i` do not reach `wave_o`. When the enable rises, the toggle starts from the level last driven while the enable was low.
- R10: After reset, `irq_o` = 0, `wave_o` = 0 and the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Operation mode; 000 = interval timer |
| start_evt_i | input | 1 | Start raises interrupt and inversion |
| clk_sel_i | input | 1 | Selects tick0_i (0) or tick1_i (1) |
| narrow_i | input | 1 | 1 = 8-bit counter, 0 = 16-bit |
| out_level_i | input | 1 | Static wave level when output enable is low |
| out_en_i | input | 1 | 1 = wave toggled by interrupt events |
| reload_i | input | 16 | Reload value |
| start_i | input | 1 | Software start strobe |
| stop_i | input | 1 | Software stop strobe |
| tick0_i | input | 1 | First prescaled clock enable |
| tick1_i | input | 1 | Second prescaled clock enable |
| irq_o | output | 1 | One-cycle interrupt pulse |
| wave_o | output | 1 | Square-wave / static output |

## Verification
The bench measures interrupt periods for reload values 0, 1 and the maximum in both widths, including a full 65536-tick period. A design that counted from reload down to one, or reloaded one tick late, would show a period that is off by one there. It drives random pulses on the unselected enable, which a design with a swapped selector would count. It also applies stop and start in the same cycle, which a design that gave start priority would restart on. It changes the software level while toggling is enabled, and a design that let the level leak through would follow those changes. A reload of 16'hAB12 in narrow mode must give a 19-tick period, and a design that loaded the upper byte would produce a far longer one.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_INTERVAL = 3'b000;
endpackage

// File: rtl/itmr_tick_select.sv
module itmr_tick_select #(
    parameter int N_SRC = 2,
    parameter int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] tick_vec,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel == SEL_W'(i)) tick = tick_vec[i];
        end
    end
endmodule

// File: rtl/itmr_count_core.sv
module itmr_count_core #(
    parameter int CNT_W    = 16,
    parameter int NARROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_ok,
    input  logic             start,
    input  logic             stop,
    input  logic             tick,
    input  logic             narrow,
    input  logic             start_evt,
    input  logic [CNT_W-1:0] reload,
    output logic             fire,
    output logic             irq,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } core_t;

    core_t st_d, st_q;
    logic [CNT_W-1:0] load_val;
    logic             fire_c;

    always_comb begin
        st_d     = st_q;
        fire_c   = 1'b0;
        load_val = reload;
        if (narrow) load_val[CNT_W-1:NARROW_W] = '0;

        if (!mode_ok) begin
            st_d.run = 1'b0;
        end else if (stop) begin
            st_d.run = 1'b0;
        end else if (start) begin
            st_d.run = 1'b1;
            st_d.cnt = load_val;
            fire_c   = start_evt;
        end else if (st_q.run && tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = load_val;
                fire_c   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end

        if (narrow) st_d.cnt[CNT_W-1:NARROW_W] = '0;
        st_d.irq = fire_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire = fire_c;
    assign irq  = st_q.irq;
    assign cnt  = st_q.cnt;
endmodule

// File: rtl/itmr_wave_out.sv
module itmr_wave_out (
    input  logic clk,
    input  logic rst_n,
    input  logic out_en,
    input  logic out_level,
    input  logic fire,
    output logic wave
);
    typedef struct packed {
        logic wave;
    } wave_t;

    wave_t wv_d, wv_q;

    always_comb begin
        wv_d = wv_q;
        if (!out_en)   wv_d.wave = out_level;
        else if (fire) wv_d.wave = ~wv_q.wave;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wv_q <= '0;
        else        wv_q <= wv_d;
    end

    assign wave = wv_q.wave;
endmodule

// File: rtl/itmr_channel.sv
module itmr_channel import itmr_pkg::*; #(
    parameter int CNT_W    = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              start_evt_i,
    input  logic              clk_sel_i,
    input  logic              narrow_i,
    input  logic              out_level_i,
    input  logic              out_en_i,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              tick0_i,
    input  logic              tick1_i,
    output logic              irq_o,
    output logic              wave_o
);
    localparam int N_SRC = 2;
    localparam int SEL_W = 1;

    logic             sel_tick;
    logic             fire;
    logic [CNT_W-1:0] cnt_q;
    logic             mode_ok;

    assign mode_ok = (mode_i == MODE_INTERVAL);

    itmr_tick_select #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_sel (
        .tick_vec ({tick1_i, tick0_i}),
        .sel      (clk_sel_i),
        .tick     (sel_tick)
    );

    itmr_count_core #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_ok   (mode_ok),
        .start     (start_i),
        .stop      (stop_i),
        .tick      (sel_tick),
        .narrow    (narrow_i),
        .start_evt (start_evt_i),
        .reload    (reload_i),
        .fire      (fire),
        .irq       (irq_o),
        .cnt       (cnt_q)
    );

    itmr_wave_out u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_en    (out_en_i),
        .out_level (out_level_i),
        .fire      (fire),
        .wave      (wave_o)
    );
endmodule

// File: rtl/itmr_channel_chk.sv
module itmr_channel_chk #(
    parameter int CNT_W    = 16,
    parameter int NARROW_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode_i,
    input logic             out_en_i,
    input logic             out_level_i,
    input logic             narrow_i,
    input logic             stop_i,
    input logic             irq_o,
    input logic             wave_o,
    input logic [CNT_W-1:0] cnt_q
);
    assert_idle_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 3'b000) |=> !irq_o);

    assert_static_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_i |=> (wave_o == $past(out_level_i)));

    assert_toggle_on_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_i |=> ((wave_o != $past(wave_o)) == irq_o));

    assert_upper_byte_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        narrow_i |=> (cnt_q[CNT_W-1:NARROW_W] == '0));

    assert_stop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !irq_o);
endmodule

bind itmr_channel itmr_channel_chk #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .out_en_i    (out_en_i),
    .out_level_i (out_level_i),
    .narrow_i    (narrow_i),
    .stop_i      (stop_i),
    .irq_o       (irq_o),
    .wave_o      (wave_o),
    .cnt_q       (cnt_q)
);

// File: tb/itmr_channel_tb_top.sv
module itmr_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'b000;
    logic        start_evt = 1'b0, clk_sel = 1'b0, narrow = 1'b0;
    logic        out_level = 1'b0, out_en = 1'b0;
    logic [15:0] reload = '0;
    logic        start = 1'b0, stop = 1'b0, tick0 = 1'b0, tick1 = 1'b0;
    logic        irq, wave;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // reference model state
    bit m_run = 0;
    bit m_wave = 0;
    int k = 0;
    int m_eff = 0;

    always #2 clk = ~clk;   // 250 MHz

    itmr_channel dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .start_evt_i(start_evt),
        .clk_sel_i(clk_sel), .narrow_i(narrow), .out_level_i(out_level),
        .out_en_i(out_en), .reload_i(reload), .start_i(start), .stop_i(stop),
        .tick0_i(tick0), .tick1_i(tick1), .irq_o(irq), .wave_o(wave)
    );

    function automatic int eff_period(input logic [15:0] d, input logic nb);
        return nb ? int'(d[7:0]) : int'(d);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            if (fails <= 20)
                $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Drive one cycle of inputs at a falling edge, predict, then check at the next falling edge.
    task automatic step(input bit t0, input bit t1, input bit st, input bit sp, input string tag);
        bit selt, exp_irq;
        tick0 = t0; tick1 = t1; start = st; stop = sp;
        selt = clk_sel ? t1 : t0;
        exp_irq = 0;
        if (mode != 3'b000) m_run = 0;
        else if (sp) m_run = 0;
        else if (st) begin
            m_run = 1; k = 0; m_eff = eff_period(reload, narrow); exp_irq = start_evt;
        end else if (m_run && selt) begin
            k++;
            exp_irq = ((k % (m_eff + 1)) == 0);
        end
        if (out_en) begin
            if (exp_irq) m_wave = ~m_wave;
        end else m_wave = out_level;
        @(posedge clk);
        @(negedge clk);
        check(irq == exp_irq, {tag, " irq"}, int'(irq), int'(exp_irq));
        check(wave == m_wave, {tag, " wave"}, int'(wave), int'(m_wave));
        tick0 = 0; tick1 = 0; start = 0; stop = 0;
    endtask

    task automatic run_case(input logic [15:0] d, input bit nb, input bit sel, input bit sevt,
                            input bit oen, input bit dense, input int n, input string tag);
        reload = d; narrow = nb; clk_sel = sel; start_evt = sevt; out_en = oen;
        step(0, 0, 1, 0, tag);
        for (int i = 0; i < n; i++) begin
            bit ts, to;
            ts = dense ? 1'b1 : 1'($urandom_range(0, 1));
            to = 1'($urandom_range(0, 1));
            if (sel) step(to, ts, 0, 0, tag);
            else     step(ts, to, 0, 0, tag);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 190000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R10: reset state
        check(irq == 1'b0, "R10 irq", int'(irq), 0);
        check(wave == 1'b0, "R10 wave", int'(wave), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(irq == 1'b0 && wave == 1'b0, "R10 idle", int'({irq, wave}), 0);

        // R3: static level follows software bit
        out_en = 0;
        for (int i = 0; i < 12; i++) begin
            out_level = 1'($urandom_range(0, 1));
            step(0, 0, 0, 0, "R3");
        end
        run_case(16'd2, 0, 0, 1, 0, 1, 12, "R3");

        // R9: enable rises, toggle starts from last level, level writes ignored
        out_level = 1; out_en = 0;
        step(0, 0, 0, 0, "R9");
        out_en = 1;
        step(0, 0, 0, 0, "R9");
        for (int i = 0; i < 6; i++) begin
            out_level = ~out_level;
            step(0, 0, 0, 0, "R9");
        end

        // R2 / R4: 16-bit periods 0, 1 and max, dense ticks give duty check
        run_case(16'd0, 0, 0, 0, 1, 1, 20, "R2");
        run_case(16'd1, 0, 0, 0, 1, 1, 20, "R4");
        run_case(16'd5, 0, 0, 0, 1, 1, 40, "R4");
        run_case(16'hFFFF, 0, 0, 0, 1, 1, 65540, "R2");

        // R7: 8-bit periods 0, 1, 255 and an upper byte that must be ignored
        run_case(16'h0000, 1, 0, 0, 1, 0, 30, "R7");
        run_case(16'h0001, 1, 0, 0, 1, 0, 30, "R7");
        run_case(16'hFFFF, 1, 0, 0, 1, 1, 520, "R7");
        run_case(16'hAB12, 1, 0, 0, 1, 1, 60, "R7");

        // R6: second enable selected, first enable random noise
        run_case(16'd3, 0, 1, 0, 1, 0, 80, "R6");
        run_case(16'd3, 0, 0, 0, 1, 0, 80, "R6");

        // R5: start event on and off
        run_case(16'd4, 0, 0, 1, 1, 1, 15, "R5");
        run_case(16'd4, 0, 0, 0, 1, 1, 15, "R5");

        // R8: stop mid-count, ticks keep coming, then stop beats start
        run_case(16'd3, 0, 0, 0, 1, 1, 10, "R8");
        step(1, 1, 0, 1, "R8");
        for (int i = 0; i < 20; i++) step(1, 1, 0, 0, "R8");
        step(1, 1, 1, 1, "R8");
        for (int i = 0; i < 10; i++) step(1, 1, 0, 0, "R8");

        // R1: non-interval mode keeps channel idle
        mode = 3'b101;
        run_case(16'd0, 0, 0, 1, 1, 1, 20, "R1");
        mode = 3'b000;
        for (int i = 0; i < 10; i++) step(1, 1, 0, 0, "R1");

        // random configurations
        for (int r = 0; r < 25; r++) begin
            run_case(16'($urandom_range(0, 40)) | (16'($urandom_range(0, 3)) << 8),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), 150, "R2");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule